// File: doc/BRIEF.md
# Fixed-Depth Hardware Return Stack

This block keeps the return addresses of a small processor core whose program counter is 12 bits wide. When the core performs a subroutine call or takes an interrupt, it raises the push input with the current program counter on the PC input, and the block files that value away without any software action. When the core executes a return, it raises the pop input, reads the saved address on the return-address output in that same cycle, and the block discards that entry.

The storage is a chain of six registers that shift on every push and pop. There is no stack pointer that software can see. When all six places are in use, a further push is still accepted: every entry moves one place deeper and the oldest address drops off the end. A sticky overflow flag records that this happened. A pop from an empty stack yields zero and sets a sticky underflow flag. The two flags clear only on reset.

Top module: `rs_return_stack`

## Requirements
- R1: After reset the stack is empty (empty_o=1, full_o=0), both sticky flags are 0, and ret_addr_o is 0.
- R2: A push with no pop stores pc_i as the new top entry. From the cycle after the push, ret_addr_o equals the pushed value and empty_o is 0.
- R3: While the stack is not empty, ret_addr_o always shows the most recently pushed entry that has not yet been removed. A pop with no push removes it, so entries come back in last-in first-out order.
- R4: The stack holds exactly six entries. full_o is 1 exactly when six entries are held, and empty_o is 1 exactly when none are held.
- R5: A push with no pop while full still stores pc_i as the top entry, drops the oldest entry, keeps the other five in order below the new one, and leaves full_o at 1.
- R6: ovf_o becomes 1 in the cycle after a push that discards an entry, and stays 1 until reset.
- R7: A pop with no push while empty leaves the stack empty, keeps ret_addr_o at 0, and sets unf_o from the next cycle until reset.
- R8: A push and a pop in the same cycle on a non-empty stack replace the top entry with pc_i and leave the entry count and the entries below unchanged. On an empty stack the same pair stores pc_i as the only entry and sets unf_o.
- R9: All 12 address bits are stored and returned unchanged, including the all-zero and all-one values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Call or interrupt entry: save pc_i |
| pop_i | input | 1 | Return: remove the top entry |
| pc_i | input | 12 | Program counter value to save |
| ret_addr_o | output | 12 | Top entry, or 0 when the stack is empty |
| empty_o | output | 1 | No entries held |
| full_o | output | 1 | Six entries held |
| ovf_o | output | 1 | Sticky: a push has discarded the oldest entry |
| unf_o | output | 1 | Sticky: a pop was made on an empty stack |

## Verification
The bench builds the block with its default depth of six and width of 12. At that size it can start from every fill level from zero to six, apply each of the three operations (push, pop, both together), and then drain the stack completely, comparing every output against an arithmetic model after each step. This covers every transition of the occupancy count, including both saturation edges. A longer run pushes past the depth several times, which shows that the oldest entries are discarded in order and that the sticky flags hold.

// File: rtl/rs_pkg.sv
package rs_pkg;

    // Movement of the register chain in one cycle
    typedef enum logic [1:0] {
        SH_HOLD = 2'd0,  // no entry changes
        SH_DOWN = 2'd1,  // push: new value enters at the top
        SH_UP   = 2'd2,  // pop: every entry moves one place toward the top
        SH_TOP  = 2'd3   // push with pop: only the top entry is rewritten
    } shift_op_e;

endpackage

// File: rtl/rs_chain_cell.sv
module rs_chain_cell #(
    parameter int W   = 12,
    parameter bit TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rs_pkg::shift_op_e op_i,
    input  logic [W-1:0]      from_above_i,
    input  logic [W-1:0]      from_below_i,
    output logic [W-1:0]      value_o
);

    typedef struct packed {
        logic [W-1:0] val;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        unique case (op_i)
            rs_pkg::SH_DOWN: cell_d.val = from_above_i;
            rs_pkg::SH_UP:   cell_d.val = from_below_i;
            rs_pkg::SH_TOP: begin
                if (TOP) begin
                    cell_d.val = from_above_i;
                end
            end
            default: cell_d = cell_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign value_o = cell_q.val;

endmodule

// File: rtl/rs_occupancy.sv
module rs_occupancy #(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    output rs_pkg::shift_op_e op_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              ovf_o,
    output logic              unf_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
        logic          unf;
    } occ_t;

    occ_t              occ_d, occ_q;
    rs_pkg::shift_op_e op_d;
    logic              is_empty;
    logic              is_full;

    always_comb begin
        occ_d    = occ_q;
        op_d     = rs_pkg::SH_HOLD;
        is_empty = (occ_q.cnt == '0);
        is_full  = (occ_q.cnt == CNT_MAX);
        unique case ({push_i, pop_i})
            2'b11: begin
                op_d = rs_pkg::SH_TOP;
                if (is_empty) begin
                    occ_d.unf = 1'b1;
                    occ_d.cnt = CNT_ONE;
                end
            end
            2'b10: begin
                op_d = rs_pkg::SH_DOWN;
                if (is_full) begin
                    occ_d.ovf = 1'b1;
                end else begin
                    occ_d.cnt = occ_q.cnt + CNT_ONE;
                end
            end
            2'b01: begin
                if (is_empty) begin
                    occ_d.unf = 1'b1;
                end else begin
                    op_d      = rs_pkg::SH_UP;
                    occ_d.cnt = occ_q.cnt - CNT_ONE;
                end
            end
            default: op_d = rs_pkg::SH_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    assign op_o    = op_d;
    assign empty_o = is_empty;
    assign full_o  = is_full;
    assign ovf_o   = occ_q.ovf;
    assign unf_o   = occ_q.unf;

endmodule

// File: rtl/rs_return_stack.sv
module rs_return_stack #(
    parameter int DEPTH = 6,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] ret_addr_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         ovf_o,
    output logic         unf_o
);

    rs_pkg::shift_op_e op_w;
    logic              empty_w;
    logic [W-1:0]      entry_w [DEPTH];

    rs_occupancy #(
        .DEPTH (DEPTH)
    ) occ_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .op_o    (op_w),
        .empty_o (empty_w),
        .full_o  (full_o),
        .ovf_o   (ovf_o),
        .unf_o   (unf_o)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [W-1:0] above_w;
        logic [W-1:0] below_w;

        if (g == 0) begin : g_top_in
            assign above_w = pc_i;
        end else begin : g_mid_in
            assign above_w = entry_w[g-1];
        end

        if (g == DEPTH - 1) begin : g_bot_in
            assign below_w = '0;
        end else begin : g_next_in
            assign below_w = entry_w[g+1];
        end

        rs_chain_cell #(
            .W   (W),
            .TOP (g == 0)
        ) cell_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .op_i         (op_w),
            .from_above_i (above_w),
            .from_below_i (below_w),
            .value_o      (entry_w[g])
        );
    end

    assign empty_o    = empty_w;
    assign ret_addr_o = empty_w ? '0 : entry_w[0];

endmodule

module rs_return_stack_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         push_i,
    input logic         pop_i,
    input logic [W-1:0] pc_i,
    input logic [W-1:0] ret_addr_o,
    input logic         empty_o,
    input logic         full_o,
    input logic         ovf_o,
    input logic         unf_o
);

    a_r4_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    a_r2_push_shows_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (ret_addr_o == $past(pc_i)) && !empty_o);

    a_r8_swap_shows_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (ret_addr_o == $past(pc_i)));

    a_r8_swap_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o) |=> $stable(full_o) && !empty_o);

    a_r5_full_push_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> full_o);

    a_r6_ovf_on_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> ovf_o);

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> unf_o && empty_o && (ret_addr_o == '0));

    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

    a_r3_pop_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> !full_o);

endmodule

bind rs_return_stack rs_return_stack_chk #(.W(W)) chk_i (.*);

// File: tb/rs_return_stack_tb.sv
`timescale 1ns/1ps
module rs_return_stack_tb_top;

    localparam int DEPTH = 6;
    localparam int W     = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push = 1'b0;
    logic         pop = 1'b0;
    logic [W-1:0] pc_in = '0;
    logic [W-1:0] ret_addr;
    logic         empty, full, ovf, unf;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 1'b0;

    int  m_stk [DEPTH];
    int  m_cnt;
    bit  m_ovf, m_unf;

    always #4 clk = ~clk;

    rs_return_stack #(.DEPTH(DEPTH), .W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .pc_i       (pc_in),
        .ret_addr_o (ret_addr),
        .empty_o    (empty),
        .full_o     (full),
        .ovf_o      (ovf),
        .unf_o      (unf)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "ret_addr", int'(ret_addr), (m_cnt == 0) ? 0 : m_stk[0]);
        chk(tag, "empty", int'(empty), int'(m_cnt == 0));
        chk(tag, "full", int'(full), int'(m_cnt == DEPTH));
        chk(tag, "ovf", int'(ovf), int'(m_ovf));
        chk(tag, "unf", int'(unf), int'(m_unf));
    endtask

    task automatic model_apply(input bit ps, input bit pp, input int pc);
        if (ps && pp) begin
            if (m_cnt == 0) begin
                m_unf = 1'b1;
                m_cnt = 1;
            end
            m_stk[0] = pc;
        end else if (ps) begin
            if (m_cnt == DEPTH) m_ovf = 1'b1;
            for (int i = DEPTH - 1; i > 0; i--) m_stk[i] = m_stk[i-1];
            m_stk[0] = pc;
            if (m_cnt < DEPTH) m_cnt++;
        end else if (pp) begin
            if (m_cnt == 0) begin
                m_unf = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH - 1; i++) m_stk[i] = m_stk[i+1];
                m_stk[DEPTH-1] = 0;
                m_cnt--;
            end
        end
    endtask

    task automatic do_op(input bit ps, input bit pp, input int pc, input string tag);
        @(negedge clk);
        push  = ps;
        pop   = pp;
        pc_in = W'(pc);
        @(posedge clk);
        model_apply(ps, pp, pc);
        #2;
        push = 1'b0;
        pop  = 1'b0;
        check_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        push  = 1'b0;
        pop   = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) m_stk[i] = 0;
        m_cnt = 0;
        m_ovf = 1'b0;
        m_unf = 1'b0;
        #1;
        check_all("R1");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // Every start level, every operation, then drain to empty and beyond
        for (int lvl = 0; lvl <= DEPTH; lvl++) begin
            for (int opk = 0; opk < 3; opk++) begin
                do_reset();
                for (int k = 0; k < lvl; k++) begin
                    do_op(1'b1, 1'b0, (lvl * 37 + k * 291 + opk * 5 + 1) & 12'hFFF, "R4");
                end
                case (opk)
                    0: do_op(1'b1, 1'b0, (lvl * 613 + 77) & 12'hFFF, (lvl == DEPTH) ? "R5" : "R2");
                    1: do_op(1'b0, 1'b1, 0, (lvl == 0) ? "R7" : "R3");
                    default: do_op(1'b1, 1'b1, (lvl * 1001 + 3) & 12'hFFF, "R8");
                endcase
                while (m_cnt > 0) do_op(1'b0, 1'b1, 0, "R3");
                do_op(1'b0, 1'b1, 0, "R7");
            end
        end

        // Repeated overrun: oldest entries fall off in order, flags persist
        do_reset();
        for (int k = 0; k < DEPTH + 3; k++) begin
            do_op(1'b1, 1'b0, (k * 419 + 11) & 12'hFFF, (k >= DEPTH) ? "R6" : "R2");
        end
        do_op(1'b1, 1'b1, 12'h5A5, "R8");
        for (int k = 0; k < DEPTH + 1; k++) do_op(1'b0, 1'b1, 0, "R5");
        do_op(1'b0, 1'b0, 0, "R6");

        // Extreme address values
        do_reset();
        do_op(1'b1, 1'b0, 12'hFFF, "R9");
        do_op(1'b1, 1'b0, 12'h000, "R9");
        do_op(1'b1, 1'b0, 12'h800, "R9");
        do_op(1'b1, 1'b0, 12'h001, "R9");
        for (int k = 0; k < 4; k++) do_op(1'b0, 1'b1, 0, "R9");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule